// File: doc/BRIEF.md
# Dual Boot Flash Failover Controller

This block supervises the boot of a host processor that can start from one of two SPI boot flash devices, a primary and a backup. When software requests a payload start, the controller selects the primary device and holds the host in reset for a programmable number of cycles. It then releases the reset and waits a programmable number of cycles for the host to report its boot status. A report of failure is handled the same way as no report at all. On the first such failure the controller moves the select line to the backup device, resets the host again and opens a new status window. A failure of the backup attempt is reported, and after that the controller stays quiet: it issues no more resets and no more switches.

For each device there is a sticky error flag and a one-cycle event strobe. The flags stay set until a synchronous clear or the next payload start. An override input lets software pin the select line to either device. While it is active, a failure is reported against the pinned device and the automatic failover sequence is skipped.

The status interface is a strobe without back-pressure. A status strobe is consumed in any cycle it is high, and it has an effect only while a status window is open. All other pins are plain level or pulse control and status.

Top module: `boot_failover`

## Requirements
- R1: After reset, `flash_sel_o` is 0 (primary), `host_rst_o` is 0, and both error flags and both event strobes are 0.
- R2: The cycle after `start_i` is sampled high, `flash_sel_o` is 0 (without override) and both error flags are 0. `host_rst_o` (active high) is then high for exactly max(`rst_len_i`,1) consecutive cycles, starting in that cycle. This holds in every state.
- R3: The status window opens in the cycle after `host_rst_o` falls. It lasts max(`timeout_i`,1) cycles. A strobe with `status_pass_i`=0 in window cycle d fails the attempt at the edge that ends cycle d. With no strobe, the attempt fails at the edge that ends the last window cycle. A pass strobe in the last cycle still counts as a pass.
- R4: Without override, a primary failure (`flash_sel_o`=0) raises `evt_pri_o` and sets `flash_sel_o` to 1 in the same cycle. A new `host_rst_o` pulse of max(`rst_len_i`,1) cycles starts in that same cycle.
- R5: A failure while `flash_sel_o`=1 raises `evt_bak_o`. After that, `host_rst_o` stays 0, `flash_sel_o` stays 1, and all status strobes are ignored until the next `start_i`.
- R6: `err_pri_o` or `err_bak_o` is set in the cycle its event strobe is high. It holds until `err_clr_i` or `start_i` is sampled high, and reads 0 in the following cycle.
- R7: A strobe with `status_pass_i`=1 inside the window ends the attempt with no event. Later status strobes cause no event, no reset and no select change until the next `start_i`.
- R8: While `ovr_en_i`=1, `flash_sel_o` equals `ovr_sel_i` in the same cycle. A failure raises the event and flag of that device, and no further reset or switch follows.
- R9: Each event strobe is high for one cycle per failure, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| start_i | input | 1 | Payload start request, one-cycle pulse |
| status_vld_i | input | 1 | Boot status strobe from the host |
| status_pass_i | input | 1 | Status value: 1 pass, 0 fail |
| timeout_i | input | TMR_W | Status window length in cycles (0 treated as 1) |
| rst_len_i | input | RST_W | Host reset pulse length in cycles (0 treated as 1) |
| ovr_en_i | input | 1 | Software override of the flash select |
| ovr_sel_i | input | 1 | Forced select value: 0 primary, 1 backup |
| err_clr_i | input | 1 | Synchronous clear of both sticky error flags |
| flash_sel_o | output | 1 | Flash select: 0 primary, 1 backup |
| host_rst_o | output | 1 | Host reset, active high |
| err_pri_o | output | 1 | Sticky primary boot failure flag |
| err_bak_o | output | 1 | Sticky backup boot failure flag |
| evt_pri_o | output | 1 | One-cycle primary failure event |
| evt_bak_o | output | 1 | One-cycle backup failure event |

## Verification
The host reset begins in the first cycle after the start edge or the failure edge. The status window opens in the cycle after the reset ends. An event strobe and the matching flag appear in the cycle after the edge that ends the failing window cycle, and the select change appears in that same cycle. The bench drives each input for exactly one edge and reads the outputs one time unit after every rising edge. It counts reset cycles and window cycles itself and predicts the failure edge as min(d, T-1) for a fail report at window cycle d. It sweeps reset lengths 0 to 3, timeouts 0 to 3, every report position up to two cycles past the window, and both status values.

// File: rtl/boot_failover_pkg.sv
package boot_failover_pkg;
  typedef enum logic [2:0] {
    BF_IDLE,
    BF_RESET,
    BF_WAIT,
    BF_BOOTED,
    BF_HALT
  } bf_state_e;

  localparam int unsigned BF_NUM_FLASH = 2;
  localparam logic        BF_SEL_PRI   = 1'b0;
  localparam logic        BF_SEL_BAK   = 1'b1;
endpackage

// File: rtl/bf_cycle_cnt.sv
module bf_cycle_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_eff;

  assign lim_eff = (lim_i == '0) ? W'(1) : lim_i;
  assign done_o  = en_i && !clr_i && (cnt_q == lim_eff - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (en_i)       cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/bf_err_flags.sv
module bf_err_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] evt_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_o[g] <= 1'b0;
        evt_o[g]  <= 1'b0;
      end else begin
        evt_o[g] <= set_i[g];
        if (set_i[g])   flag_o[g] <= 1'b1;
        else if (clr_i) flag_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/boot_failover.sv
module boot_failover
  import boot_failover_pkg::*;
#(
  parameter int unsigned TMR_W = 16,
  parameter int unsigned RST_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             status_vld_i,
  input  logic             status_pass_i,
  input  logic [TMR_W-1:0] timeout_i,
  input  logic [RST_W-1:0] rst_len_i,
  input  logic             ovr_en_i,
  input  logic             ovr_sel_i,
  input  logic             err_clr_i,
  output logic             flash_sel_o,
  output logic             host_rst_o,
  output logic             err_pri_o,
  output logic             err_bak_o,
  output logic             evt_pri_o,
  output logic             evt_bak_o
);
  bf_state_e state_q;
  logic      use_bak_q;
  logic      rst_done, tmo_done;
  logic      pass_ev, fail_ev;
  logic [BF_NUM_FLASH-1:0] fail_set, flags, evts;

  assign flash_sel_o = ovr_en_i ? ovr_sel_i : use_bak_q;
  assign host_rst_o  = (state_q == BF_RESET);

  bf_cycle_cnt #(.W(RST_W)) u_rst_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr_i(start_i || state_q != BF_RESET),
    .en_i(state_q == BF_RESET),
    .lim_i(rst_len_i),
    .done_o(rst_done)
  );

  bf_cycle_cnt #(.W(TMR_W)) u_win_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr_i(start_i || state_q != BF_WAIT),
    .en_i(state_q == BF_WAIT),
    .lim_i(timeout_i),
    .done_o(tmo_done)
  );

  // A pass report wins over a timeout that expires in the same cycle.
  assign pass_ev = (state_q == BF_WAIT) && !start_i && status_vld_i && status_pass_i;
  assign fail_ev = (state_q == BF_WAIT) && !start_i && !pass_ev &&
                   (status_vld_i || tmo_done);

  assign fail_set[0] = fail_ev && (flash_sel_o == BF_SEL_PRI);
  assign fail_set[1] = fail_ev && (flash_sel_o == BF_SEL_BAK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= BF_IDLE;
      use_bak_q <= BF_SEL_PRI;
    end else if (start_i) begin
      state_q   <= BF_RESET;
      use_bak_q <= BF_SEL_PRI;
    end else begin
      unique case (state_q)
        BF_RESET: if (rst_done) state_q <= BF_WAIT;
        BF_WAIT: begin
          if (pass_ev) begin
            state_q <= BF_BOOTED;
          end else if (fail_ev) begin
            if (!ovr_en_i && use_bak_q == BF_SEL_PRI) begin
              use_bak_q <= BF_SEL_BAK;
              state_q   <= BF_RESET;
            end else begin
              state_q <= BF_HALT;
            end
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end

  bf_err_flags #(.N(BF_NUM_FLASH)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .clr_i(err_clr_i || start_i),
    .set_i(fail_set),
    .flag_o(flags),
    .evt_o(evts)
  );

  assign err_pri_o = flags[0];
  assign err_bak_o = flags[1];
  assign evt_pri_o = evts[0];
  assign evt_bak_o = evts[1];
endmodule

// File: rtl/bf_failover_chk.sv
module bf_failover_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic ovr_en_i,
  input logic err_clr_i,
  input logic flash_sel_o,
  input logic host_rst_o,
  input logic err_pri_o,
  input logic err_bak_o,
  input logic evt_pri_o,
  input logic evt_bak_o
);
  // R9
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_pri_o, evt_bak_o}));

  // R4
  pri_fail_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pri_o && !$past(ovr_en_i) |-> host_rst_o && flash_sel_o);

  // R5
  bak_fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bak_o |-> !host_rst_o);

  // R6
  pri_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pri_o |-> err_pri_o) and (evt_bak_o |-> err_bak_o));

  // R6
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_pri_o) || $fell(err_bak_o) |-> $past(err_clr_i || start_i));

  // R2
  reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rst_o) |-> $past(start_i) || evt_pri_o);

  // R4
  switch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_en_i && !$past(ovr_en_i) && $rose(flash_sel_o) |-> evt_pri_o);
endmodule

bind boot_failover bf_failover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ovr_en_i(ovr_en_i),
  .err_clr_i(err_clr_i), .flash_sel_o(flash_sel_o), .host_rst_o(host_rst_o),
  .err_pri_o(err_pri_o), .err_bak_o(err_bak_o),
  .evt_pri_o(evt_pri_o), .evt_bak_o(evt_bak_o)
);

// File: tb/boot_failover_tb.sv
module boot_failover_tb;
  localparam int TMR_W = 8;
  localparam int RST_W = 4;

  logic clk = 0, rst_n = 0;
  logic start = 0, vld = 0, pass = 0, ovr_en = 0, ovr_sel = 0, err_clr = 0;
  logic [TMR_W-1:0] tmo = '0;
  logic [RST_W-1:0] rlen = '0;
  logic flash_sel, host_rst, err_pri, err_bak, evt_pri, evt_bak;
  int nchk = 0, nfail = 0, cyc = 0;

  always #5 clk = ~clk;

  boot_failover #(.TMR_W(TMR_W), .RST_W(RST_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .status_vld_i(vld),
    .status_pass_i(pass), .timeout_i(tmo), .rst_len_i(rlen),
    .ovr_en_i(ovr_en), .ovr_sel_i(ovr_sel), .err_clr_i(err_clr),
    .flash_sel_o(flash_sel), .host_rst_o(host_rst), .err_pri_o(err_pri),
    .err_bak_o(err_bak), .evt_pri_o(evt_pri), .evt_bak_o(evt_bak)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    start = 1; step(); start = 0;
  endtask

  task automatic count_rst(output int n);
    n = 0;
    while (host_rst && n < 64) begin n++; step(); end
  endtask

  // Runs a status window; reports the index of the edge whose sample shows an event.
  task automatic window(input int d, input int p, input int lim, output int got);
    got = -1;
    for (int i = 0; i < lim; i++) begin
      vld = (i == d); pass = p[0];
      step();
      vld = 0;
      if (evt_pri || evt_bak) begin got = i; break; end
      if (i == d && p == 1) break;
    end
  endtask

  function automatic int exp_fail(int d, int p, int te);
    if (d < te) return (p == 1) ? -1 : d;
    return te - 1;
  endfunction

  task automatic quiet(string req, int sel);
    for (int k = 0; k < 3; k++) begin
      vld = 1; pass = k[0]; step(); vld = 0;
      chk(req, {host_rst, evt_pri, evt_bak}, 0);
      chk(req, flash_sel, sel);
    end
  endtask

  initial begin
    int n, got, le, te, e, d2;
    repeat (3) step();
    rst_n = 1;
    chk("R1 sel", flash_sel, 0);
    chk("R1 rst", host_rst, 0);
    chk("R1 flags/evts", {err_pri, err_bak, evt_pri, evt_bak}, 0);

    for (int l = 0; l < 4; l++)
      for (int t = 0; t < 4; t++) begin
        le = (l == 0) ? 1 : l;
        te = (t == 0) ? 1 : t;
        for (int d = 0; d < te + 2; d++)
          for (int p = 0; p < 2; p++) begin
            rlen = RST_W'(l); tmo = TMR_W'(t);
            do_start();
            chk("R2 flags clear", {err_pri, err_bak}, 0);
            chk("R2 sel primary", flash_sel, 0);
            count_rst(n);
            chk("R2 reset length", n, le);
            window(d, p, te + 2, got);
            e = exp_fail(d, p, te);
            if (e < 0) begin
              chk("R7 pass no event", got, -1);
              quiet("R7 booted ignores status", 0);
            end else begin
              chk("R3 fail edge", got, e);
              chk("R4 evt_pri", {evt_pri, evt_bak}, 2);
              chk("R4 switched", flash_sel, 1);
              chk("R6 err_pri set", err_pri, 1);
              count_rst(n);
              chk("R4 second reset length", n, le);
              d2 = (d + 1) % (te + 2);
              window(d2, 0, te + 2, got);
              chk("R3 backup fail edge", got, exp_fail(d2, 0, te));
              chk("R5 evt_bak", {evt_pri, evt_bak}, 1);
              chk("R6 both flags", {err_pri, err_bak}, 3);
              step();
              chk("R9 strobe one cycle", evt_bak, 0);
              quiet("R5 halt ignores status", 1);
            end
          end
      end

    // R6: flags hold, then the clear input drops them
    rlen = 1; tmo = 2;
    do_start(); count_rst(n); window(0, 0, 4, got);
    count_rst(n); window(0, 0, 4, got);
    repeat (5) step();
    chk("R6 flags hold", {err_pri, err_bak}, 3);
    err_clr = 1; step(); err_clr = 0;
    chk("R6 clear", {err_pri, err_bak}, 0);

    // R8: override to backup
    ovr_en = 1; ovr_sel = 1; #1;
    chk("R8 sel follows override", flash_sel, 1);
    do_start(); count_rst(n);
    chk("R8 reset length", n, 1);
    window(0, 0, 4, got);
    chk("R8 fail edge", got, 0);
    chk("R8 evt_bak only", {evt_pri, evt_bak}, 1);
    chk("R8 flags", {err_pri, err_bak}, 1);
    quiet("R8 no failover", 1);

    // R8: override to primary, timeout
    ovr_sel = 0; tmo = 3;
    do_start(); count_rst(n);
    window(99, 0, 6, got);
    chk("R8 timeout edge", got, 2);
    chk("R8 evt_pri only", {evt_pri, evt_bak}, 2);
    chk("R8 no reset after fail", host_rst, 0);
    quiet("R8 no failover primary", 0);
    ovr_en = 0;

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule